// File: doc/BRIEF.md
# Decimal Adjust Unit for Packed BCD Arithmetic

After the ALU adds or subtracts two packed BCD bytes in binary, the accumulator can hold an illegal digit, or a digit that is off by six. This unit takes that raw accumulator byte and the half-carry, subtract and carry flags that the operation produced. It returns the corrected two-digit BCD byte and a new flag byte. The correction is 0x00, 0x06, 0x60 or 0x66. The unit picks it from both nibbles and the incoming half-carry and carry. When the subtract flag is set, the correction is subtracted instead of added.

The flag byte uses this bit order, from bit 7 down to bit 0: sign, zero, result bit 5, half-carry, result bit 3, parity, subtract, carry. The adjust logic is combinational. A parameter chooses whether a register stage follows it. With the register stage, a one-cycle enable strobe captures a result. The outputs then hold until the next strobe, and a valid pulse marks each update.

Top module: `bcd_adjust`

## Requirements
- R1: With subtract=0, 0x06 is added when the low nibble is above 9 or half-carry is 1.
- R2: With subtract=0, 0x60 is added when the whole byte is above 0x99 or carry is 1. Both corrections may apply together, giving 0x66.
- R3: With subtract=1, the same selection rules apply, but the chosen corrections are subtracted modulo 256.
- R4: In flag_out, bit 7 is the sign (result bit 7). Bit 6 is 1 when the result is 0x00. Bit 5 and bit 3 copy result bits 5 and 3. Bit 2 is 1 when the result has an even number of ones.
- R5: flag_out bit 0 (carry) is 1 exactly when the 0x60 correction was used, so an incoming carry of 1 always gives carry out 1.
- R6: flag_out bit 4 (half-carry) is set as follows. For addition, it is 1 when the low nibble is above 9. For subtraction, it is 1 when the incoming half-carry was 1 and the low nibble was below 6.
- R7: flag_out bit 1 (subtract) equals the incoming subtract flag.
- R8: With the register stage (REG_OUT=1), an enable strobe in one cycle updates the outputs at that clock edge and raises valid_out for one cycle. While enable is low, the outputs hold their values.
- R9: While rst_n is low, acc_out, flag_out and valid_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Strobe that captures a new adjust result |
| acc_in | input | 8 | Accumulator value before adjustment |
| h_in | input | 1 | Half-carry from the preceding operation |
| n_in | input | 1 | Subtract flag from the preceding operation |
| c_in | input | 1 | Carry from the preceding operation |
| acc_out | output | 8 | Adjusted accumulator |
| flag_out | output | 8 | New flag byte (S Z b5 H b3 P N C) |
| valid_out | output | 1 | One-cycle pulse after a strobe |

## Verification
With the default register stage, the adjusted byte, the flag byte and the valid pulse are all due at the first rising edge after the cycle in which en is high. No output is due in the strobe cycle itself. The bench changes inputs and en on falling edges and drops en after one cycle. It reads all three outputs on the falling edge that follows, half a period after they update. For the hold checks, inputs change while en is low, and the outputs are read two falling edges later to show nothing moved. Every vector is compared against a reference function in the bench, and a full sweep covers all 256 bytes with all eight flag combinations.

// File: rtl/bcd_adjust.sv
module bcd_adjust #(
  parameter bit REG_OUT = 1'b1,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] acc_in,
  input  logic         h_in,
  input  logic         n_in,
  input  logic         c_in,
  output logic [W-1:0] acc_out,
  output logic [7:0]   flag_out,
  output logic         valid_out
);

  localparam logic [W-1:0] LO_FIX = W'(8'h06);
  localparam logic [W-1:0] HI_FIX = W'(8'h60);

  logic [3:0]   lo_nib;
  logic         fix_lo, fix_hi;
  logic [W-1:0] corr, res;
  logic         half_nxt;
  logic [7:0]   flags_nxt;

  assign lo_nib   = acc_in[3:0];
  assign fix_lo   = (lo_nib > 4'd9) | h_in;
  assign fix_hi   = (acc_in > W'(8'h99)) | c_in;
  assign corr     = (fix_lo ? LO_FIX : '0) | (fix_hi ? HI_FIX : '0);
  assign res      = n_in ? (acc_in - corr) : (acc_in + corr);
  assign half_nxt = n_in ? (h_in & (lo_nib < 4'd6)) : (lo_nib > 4'd9);

  assign flags_nxt = {res[7], (res == '0), res[5], half_nxt,
                      res[3], ~^res[7:0], n_in, fix_hi};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc_out   <= '0;
          flag_out  <= '0;
          valid_out <= 1'b0;
        end else begin
          valid_out <= en;
          if (en) begin
            acc_out  <= res;
            flag_out <= flags_nxt;
          end
        end
      end

      assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> valid_out);
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc_out) && $stable(flag_out)));
      assert_carry_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && c_in) |=> flag_out[0]);
      assert_sub_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (flag_out[1] == $past(n_in)));
      assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (flag_out[6] == (acc_out == '0)));
      assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (flag_out[2] == ~^acc_out[7:0]));
      assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && acc_out == '0 && flag_out == '0));
    end else begin : g_comb
      assign acc_out   = rst_n ? res : '0;
      assign flag_out  = rst_n ? flags_nxt : '0;
      assign valid_out = rst_n & en;
    end
  endgenerate

endmodule

// File: tb/bcd_adjust_bench.sv
module bcd_adjust_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] acc_in = '0;
  logic h_in = 1'b0, n_in = 1'b0, c_in = 1'b0;
  logic [7:0] acc_out, flag_out;
  logic valid_out;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_adjust u_bcd_adjust (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_in(acc_in),
    .h_in(h_in), .n_in(n_in), .c_in(c_in),
    .acc_out(acc_out), .flag_out(flag_out), .valid_out(valid_out));

  function automatic logic [15:0] ref_model(input logic [7:0] a, input logic h,
                                             input logic n, input logic c);
    logic lo_big, need_lo, need_hi, hh;
    logic [7:0] delta, r;
    lo_big  = a[3:0] >= 4'hA;
    need_lo = lo_big || h;
    need_hi = (a >= 8'h9A) || c;
    delta   = 8'h00;
    if (need_lo) delta = delta + 8'h06;
    if (need_hi) delta = delta + 8'h60;
    r  = n ? 8'(a - delta) : 8'(a + delta);
    hh = n ? (h && (a[3:0] <= 4'h5)) : lo_big;
    return {r, r[7], (r == 8'h00), r[5], hh, r[3], ~(^r), n, need_hi};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic h, input logic n, input logic c);
    @(negedge clk);
    acc_in = a; h_in = h; n_in = n; c_in = c; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 acc", 32'(acc_out), 32'h00);
    check("R9 flags", 32'(flag_out), 32'h00);
    check("R9 valid", 32'(valid_out), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_add;
    apply(8'h0F, 1'b0, 1'b0, 1'b0);
    check("R1 acc 0F", 32'(acc_out), 32'h15);
    check("R6 R4 flags 0F", 32'(flag_out), 32'h10);
    check("R8 valid", 32'(valid_out), 32'h1);
    apply(8'h9A, 1'b0, 1'b0, 1'b0);
    check("R2 acc 9A", 32'(acc_out), 32'h00);
    check("R2 R4 flags 9A", 32'(flag_out), 32'h55);
    apply(8'h42, 1'b1, 1'b0, 1'b0);
    check("R1 half-in acc", 32'(acc_out), 32'h48);
    check("R6 half-out clear", 32'(flag_out[4]), 32'h0);
  endtask

  task automatic t_sub;
    apply(8'h0F, 1'b1, 1'b1, 1'b0);
    check("R3 acc", 32'(acc_out), 32'h09);
    check("R3 R7 flags", 32'(flag_out), 32'h0E);
    apply(8'h03, 1'b1, 1'b1, 1'b0);
    check("R6 sub half", 32'(flag_out[4]), 32'h1);
    check("R3 wrap acc", 32'(acc_out), 32'hFD);
  endtask

  task automatic t_carry;
    apply(8'h12, 1'b0, 1'b0, 1'b1);
    check("R5 acc", 32'(acc_out), 32'h72);
    check("R5 carry kept", 32'(flag_out[0]), 32'h1);
  endtask

  task automatic t_hold;
    logic [7:0] a0, f0;
    apply(8'h27, 1'b0, 1'b0, 1'b0);
    a0 = acc_out; f0 = flag_out;
    @(negedge clk);
    acc_in = 8'hFF; h_in = 1'b1; c_in = 1'b1;
    check("R8 valid drop", 32'(valid_out), 32'h0);
    repeat (2) @(negedge clk);
    check("R8 hold acc", 32'(acc_out), 32'(a0));
    check("R8 hold flags", 32'(flag_out), 32'(f0));
  endtask

  task automatic t_sweep;
    logic [15:0] e;
    for (int v = 0; v < 2048; v++) begin
      apply(v[7:0], v[8], v[9], v[10]);
      e = ref_model(v[7:0], v[8], v[9], v[10]);
      check("R1 R2 R3 sweep acc", 32'(acc_out), 32'(e[15:8]));
      check("R4 R5 R6 R7 sweep flags", 32'(flag_out), 32'(e[7:0]));
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_carry();
    t_hold();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule